// File: doc/BRIEF.md
# ADC Channel Scan Controller

This block is a small register file that drives an analog-to-digital converter through a channel scan. A CPU reaches it over a simple bus: an address, read and write strobes, and a wide flag that tells a 16-bit access from a byte access. Byte registers hold the scan range, the interrupt setup, the pace source and the conversion enable. Two read-only bytes report the board straps, the live channel and the conversion events. A 16-bit access at offset 0 does two jobs. A write of any value starts one conversion. A read returns the latest result.

A conversion can be started by software, by an edge on an external pace pin, or by a pulse from an internal pacer. The block issues a one-cycle start to the converter and waits for the converter's busy signal to fall. It then latches the 16-bit result and steps the multiplexer to the next channel of the scan. The occupancy of an outside sample FIFO is used to derive the not-empty and half-full flags. One of four conversion events can be routed to a sticky interrupt.

Top module: `adc_scan_regs`

## Requirements
- R1: After reset, the status byte at offset 4 reads {busy=0, unipolar strap, single-ended strap, fast-clock strap, channel 0} in bits 7..0. The conversion status byte at offset 5 reads 0 when the FIFO is empty, and irq is low.
- R2: A byte write to offset 0 stores the first channel in bits 3:0 and the last channel in bits 7:4. It also reads back unchanged and moves mux_sel and status bits 3:0 to the first channel.
- R3: Status bit 7 is set from the cycle after a trigger is accepted. It clears once the converter's busy has fallen. Each accepted trigger gives exactly one cnv_start pulse.
- R4: A 16-bit read of offset 0 returns the result latched at the end of the last conversion. Conversion status bit 7 (end of conversion) is set at that end and cleared by this read.
- R5: After each conversion the channel advances by one. A conversion on the last channel returns it to the first channel and sets conversion status bit 6 (end of scan), which clears at the next conversion that does not wrap. With first equal to last, every conversion wraps.
- R6: When burst register (offset 3) bit 0 is clear, triggers from every source are ignored: no cnv_start, busy stays 0, and the channel does not move.
- R7: Pacer register (offset 2) bits 1:0 pick the trigger: 0 means software writes, 2 means a rising edge of pace_ext XOR bit 2, and 3 means pace_int pulses. A source that is not selected has no effect.
- R8: A trigger accepted while a conversion is in flight is dropped and sets the overrun flag. The flag shows in conversion status bit 2 and interrupt register bit 4. A read of offset 5 clears it.
- R9: Conversion status bit 4 is set when fifo_level is non-zero. Bit 3 is set when fifo_level is at least FIFO_DEPTH/2.
- R10: Interrupt register (offset 1) bits 1:0 pick the event: 0 end of conversion, 1 FIFO not empty, 2 end of scan, 3 see R11. The event sets the pending bit 6, which stays set until a write with bit 6 set. irq is pending AND enable bit 7.
- R11: With select 3, interrupt bit 2 clear routes FIFO half-full, and bit 2 set routes end of acquisition. End of acquisition is a scan wrap while burst bit 1 is set, and it shows in conversion status bit 5 and interrupt bit 3.
- R12: Pacer bit 3 set blocks external and internal pace triggers unless the gate is active. The gate is active when pace_gate XOR pacer bit 5 is 1. Pacer bit 6 reads that gate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wide | input | 1 | 1 for a 16-bit access |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| strap_unipolar | input | 1 | Input polarity strap |
| strap_single_ended | input | 1 | Input mode strap |
| strap_fast_clk | input | 1 | Pacer clock strap |
| pace_ext | input | 1 | External pace input |
| pace_int | input | 1 | Internal pacer pulse |
| pace_gate | input | 1 | Pacer gate input |
| fifo_level | input | LVL_W | Sample FIFO occupancy |
| cnv_start | output | 1 | Converter start pulse |
| cnv_busy | input | 1 | Converter busy |
| cnv_result | input | 16 | Converter result |
| mux_sel | output | 4 | Current multiplexer channel |
| irq | output | 1 | Interrupt request |

## Verification
Read data is registered, so a read strobe driven before a rising edge is sampled at the falling edge that follows. A write changes the register state at the edge it is sampled on. A software trigger therefore shows as status bit 7 on the very next read, and cnv_start rises one edge after the trigger. The end of a conversion comes one edge after the converter's busy falls. Because of this the bench polls status bit 7 until it clears before it reads the result, the channel, the scan flags or irq. It never waits a fixed delay that would depend on converter latency.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int CH_W   = 4;
    localparam int WORD_W = 16;

    localparam logic [2:0] OFS_SCAN  = 3'd0;
    localparam logic [2:0] OFS_IRQ   = 3'd1;
    localparam logic [2:0] OFS_PACER = 3'd2;
    localparam logic [2:0] OFS_BURST = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;
    localparam logic [2:0] OFS_CSTAT = 3'd5;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_NONE = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_INT  = 2'd3
    } pace_src_e;

    typedef enum logic [1:0] {
        EVT_EOC  = 2'd0,
        EVT_FNE  = 2'd1,
        EVT_EOB  = 2'd2,
        EVT_ALT  = 2'd3
    } irq_src_e;
endpackage

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adc_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       ext_pol,
    input  logic       gate_en,
    input  logic       gate_active,
    input  logic       sw_req,
    input  logic       pace_ext,
    input  logic       pace_int,
    output logic       trig
);
    logic lvl_d, lvl_q;
    logic ext_edge, gate_ok;

    always_comb begin
        lvl_d    = pace_ext ^ ext_pol;
        ext_edge = lvl_d & ~lvl_q;
        gate_ok  = ~gate_en | gate_active;
        unique case (pace_src_e'(src))
            SRC_SW:  trig = sw_req;
            SRC_EXT: trig = ext_edge & gate_ok;
            SRC_INT: trig = pace_int & gate_ok;
            default: trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic            conv_en,
    input  logic            load_scan,
    input  logic [CH_W-1:0] first_new,
    input  logic [CH_W-1:0] first_cur,
    input  logic [CH_W-1:0] last_cur,
    input  logic            cnv_busy,
    output logic            cnv_start,
    output logic            busy,
    output logic            done,
    output logic            wrap,
    output logic            ovr_evt,
    output logic [CH_W-1:0] chan
);
    typedef struct packed {
        logic            busy;
        logic            start;
        logic            cb_prev;
        logic [CH_W-1:0] chan;
    } seq_t;

    seq_t q, d;
    logic start_now;

    always_comb begin
        d         = q;
        start_now = trig & conv_en & ~q.busy;
        ovr_evt   = trig & conv_en & q.busy;
        done      = q.busy & q.cb_prev & ~cnv_busy;
        wrap      = done & (q.chan == last_cur);
        d.start   = start_now;
        d.cb_prev = cnv_busy;
        if (start_now)  d.busy = 1'b1;
        else if (done)  d.busy = 1'b0;
        if (load_scan)  d.chan = first_new;
        else if (wrap)  d.chan = first_cur;
        else if (done)  d.chan = q.chan + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnv_start = q.start;
    assign busy      = q.busy;
    assign chan      = q.chan;
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_wide,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              strap_unipolar,
    input  logic              strap_single_ended,
    input  logic              strap_fast_clk,
    input  logic              pace_ext,
    input  logic              pace_int,
    input  logic              pace_gate,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              cnv_start,
    input  logic              cnv_busy,
    input  logic [WORD_W-1:0] cnv_result,
    output logic [CH_W-1:0]   mux_sel,
    output logic              irq
);
    localparam int HALF = FIFO_DEPTH / 2;

    typedef struct packed {
        logic [CH_W-1:0]   first;
        logic [CH_W-1:0]   last;
        logic              irq_en;
        logic              pend;
        logic              alt_eoa;
        logic [1:0]        irq_sel;
        logic [5:0]        pacer;
        logic              burst_mode;
        logic              conv_en;
        logic              eoc;
        logic              eob;
        logic              eoa;
        logic              ovr;
        logic [WORD_W-1:0] sample;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic wr_byte, wr_word0, rd_word0, rd_cstat, load_scan, pend_clr;
    logic gate_active, fne, fhf, evt, trig, conv_en;
    logic seq_busy, seq_done, seq_wrap, seq_ovr;
    logic [CH_W-1:0] seq_chan, scan_first, scan_last;

    assign wr_byte     = bus_wr & ~bus_wide;
    assign wr_word0    = bus_wr & bus_wide & (bus_addr == OFS_SCAN);
    assign rd_word0    = bus_rd & bus_wide & (bus_addr == OFS_SCAN);
    assign rd_cstat    = bus_rd & ~bus_wide & (bus_addr == OFS_CSTAT);
    assign load_scan   = wr_byte & (bus_addr == OFS_SCAN);
    assign pend_clr    = wr_byte & (bus_addr == OFS_IRQ) & bus_wdata[6];
    assign gate_active = pace_gate ^ q.pacer[5];
    assign fne         = (fifo_level != '0);
    assign fhf         = (fifo_level >= LVL_W'(HALF));
    assign conv_en     = q.conv_en;
    assign scan_first  = q.first;
    assign scan_last   = q.last;

    adc_trig_gen u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (q.pacer[1:0]),
        .ext_pol     (q.pacer[2]),
        .gate_en     (q.pacer[3]),
        .gate_active (gate_active),
        .sw_req      (wr_word0),
        .pace_ext    (pace_ext),
        .pace_int    (pace_int),
        .trig        (trig)
    );

    adc_scan_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .conv_en   (q.conv_en),
        .load_scan (load_scan),
        .first_new (bus_wdata[CH_W-1:0]),
        .first_cur (q.first),
        .last_cur  (q.last),
        .cnv_busy  (cnv_busy),
        .cnv_start (cnv_start),
        .busy      (seq_busy),
        .done      (seq_done),
        .wrap      (seq_wrap),
        .ovr_evt   (seq_ovr),
        .chan      (seq_chan)
    );

    always_comb begin
        d = q;
        // register writes
        if (wr_byte) begin
            unique case (bus_addr)
                OFS_SCAN: begin
                    d.first = bus_wdata[3:0];
                    d.last  = bus_wdata[7:4];
                end
                OFS_IRQ: begin
                    d.irq_en  = bus_wdata[7];
                    d.alt_eoa = bus_wdata[2];
                    d.irq_sel = bus_wdata[1:0];
                end
                OFS_PACER: d.pacer = bus_wdata[5:0];
                OFS_BURST: begin
                    d.burst_mode = bus_wdata[1];
                    d.conv_en    = bus_wdata[0];
                end
                default: ;
            endcase
        end
        // conversion events
        if (rd_word0) d.eoc = 1'b0;
        if (seq_done) begin
            d.sample = cnv_result;
            d.eoc    = 1'b1;
            d.eob    = seq_wrap;
            d.eoa    = seq_wrap & q.burst_mode;
        end
        if (rd_cstat) d.ovr = 1'b0;
        if (seq_ovr)  d.ovr = 1'b1;
        // interrupt event
        unique case (irq_src_e'(q.irq_sel))
            EVT_EOC: evt = seq_done;
            EVT_FNE: evt = fne;
            EVT_EOB: evt = seq_wrap;
            default: evt = q.alt_eoa ? (seq_wrap & q.burst_mode) : fhf;
        endcase
        if (pend_clr) d.pend = 1'b0;
        if (evt)      d.pend = 1'b1;
        // registered read data
        if (bus_rd) begin
            if (bus_wide) begin
                d.rdata = (bus_addr == OFS_SCAN) ? q.sample : '0;
            end else begin
                unique case (bus_addr)
                    OFS_SCAN:  d.rdata = {8'h00, q.last, q.first};
                    OFS_IRQ:   d.rdata = {8'h00, q.irq_en, q.pend, 1'b0, q.ovr,
                                          q.eoa, q.alt_eoa, q.irq_sel};
                    OFS_PACER: d.rdata = {8'h00, 1'b0, gate_active, q.pacer};
                    OFS_BURST: d.rdata = {14'h0000, q.burst_mode, q.conv_en};
                    OFS_STAT:  d.rdata = {8'h00, seq_busy, strap_unipolar,
                                          strap_single_ended, strap_fast_clk, seq_chan};
                    OFS_CSTAT: d.rdata = {8'h00, q.eoc, q.eob, q.eoa, fne, fhf,
                                          q.ovr, 2'b00};
                    default:   d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign mux_sel   = seq_chan;
    assign irq       = q.irq_en & q.pend;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cnv_start,
    input logic            cnv_busy,
    input logic            busy,
    input logic            conv_en,
    input logic            done,
    input logic            wrap,
    input logic            load_scan,
    input logic [CH_W-1:0] chan,
    input logic [CH_W-1:0] first,
    input logic            pend,
    input logic            pend_clr
);
    // R6: no start pulse follows a cycle with conversions disabled
    a_r6_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> !cnv_start);

    // R3: a start pulse lasts one cycle and coincides with busy
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> busy);

    // R3: busy only drops after the converter has released its busy
    a_r3_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(cnv_busy));

    // R5: a wrapping conversion returns the channel to the first one
    a_r5_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wrap && !load_scan) |=> (chan == $past(first)));

    // R10: the pending flag holds until an explicit clear
    a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);
endmodule

bind adc_scan_regs adc_scan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_start (cnv_start),
    .cnv_busy  (cnv_busy),
    .busy      (seq_busy),
    .conv_en   (conv_en),
    .done      (seq_done),
    .wrap      (seq_wrap),
    .load_scan (load_scan),
    .chan      (seq_chan),
    .first     (scan_first),
    .pend      (q.pend),
    .pend_clr  (pend_clr)
);

// File: tb/sim_adc_scan_regs.sv
module sim_adc_scan_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int LAT        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pace_ext = 1'b0, pace_int = 1'b0, pace_gate = 1'b0;
    logic [LW-1:0] fifo_level = '0;
    logic        cnv_start;
    logic        cnv_busy = 1'b0;
    logic [15:0] cnv_result = '0;
    logic [3:0]  mux_sel;
    logic        irq;

    int checks = 0, fails = 0, nstart = 0, cnt = 0, seqno = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_regs #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .strap_unipolar(1'b1), .strap_single_ended(1'b0),
        .strap_fast_clk(1'b1), .pace_ext(pace_ext), .pace_int(pace_int),
        .pace_gate(pace_gate), .fifo_level(fifo_level), .cnv_start(cnv_start),
        .cnv_busy(cnv_busy), .cnv_result(cnv_result), .mux_sel(mux_sel), .irq(irq)
    );

    // converter stub: result tags a sequence number and the sampled channel
    always @(posedge clk) begin
        if (cnv_start) begin
            nstart     <= nstart + 1;
            seqno      <= seqno + 1;
            cnv_busy   <= 1'b1;
            cnt        <= LAT;
            cnv_result <= {seqno[11:0], mux_sel};
        end else if (cnv_busy) begin
            if (cnt == 0) cnv_busy <= 1'b0;
            else          cnt <= cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input bit w, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wide = w; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit w, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wide = w; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wide = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 60; i++) begin
            rd(3'd4, 1'b0, s);
            if (!s[7]) return;
        end
        chk(1'b0, "R3 busy never cleared", 1, 0);
    endtask

    task automatic pulse_int();
        @(negedge clk); pace_int = 1'b1;
        @(negedge clk); pace_int = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [3:0] next_ch(input logic [3:0] c, input logic [3:0] f,
                                           input logic [3:0] l);
        return (c == l) ? f : c + 4'd1;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [3:0] f, l, ec;
        int n0, seed;
        bit bm;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd4, 1'b0, v); chk(v == 16'h0050, "R1 status reset", v, 16'h0050);
        rd(3'd5, 1'b0, v); chk(v == 16'h0000, "R1 cstat reset", v, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // R2 scan register
        wr(3'd0, 1'b0, 16'h0052);
        rd(3'd0, 1'b0, v); chk(v == 16'h0052, "R2 scan readback", v, 16'h52);
        chk(mux_sel == 4'd2, "R2 mux_sel first", mux_sel, 2);

        // R6 disabled: software trigger ignored
        n0 = nstart;
        wr(3'd0, 1'b1, 16'h1234);
        repeat (4) @(negedge clk);
        rd(3'd4, 1'b0, v);
        chk(nstart == n0 && v[7] == 1'b0 && v[3:0] == 4'd2, "R6 disabled trigger",
            v, 16'h0052);

        // R3 / R4 single conversion
        wr(3'd3, 1'b0, 16'h0001);
        n0 = nstart;
        wr(3'd0, 1'b1, 16'h0000);
        rd(3'd4, 1'b0, v); chk(v[7] == 1'b1, "R3 busy set", v[7], 1);
        wait_idle();
        chk(nstart == n0 + 1, "R3 one start", nstart - n0, 1);
        rd(3'd4, 1'b0, v); chk(v[3:0] == 4'd3, "R5 advance", v[3:0], 3);
        rd(3'd5, 1'b0, v); chk(v[7] == 1'b1, "R4 eoc set", v[7], 1);
        rd(3'd0, 1'b1, v); chk(v[3:0] == 4'd2, "R4 result channel", v[3:0], 2);
        rd(3'd5, 1'b0, v); chk(v[7] == 1'b0, "R4 eoc cleared by read", v[7], 0);

        // R5 random scans, burst mode random (R11 eoa flag)
        for (int it = 0; it < 8; it++) begin
            f  = 4'($urandom % 16);
            l  = f + 4'($urandom % (16 - f));
            bm = 1'($urandom % 2);
            if (it == 0) l = f;
            wr(3'd3, 1'b0, {14'h0, bm, 1'b1});
            wr(3'd0, 1'b0, {8'h00, l, f});
            ec = f;
            for (int k = 0; k < int'(l - f) * 2 + 3; k++) begin
                wr(3'd0, 1'b1, 16'hFFFF);
                wait_idle();
                rd(3'd0, 1'b1, v);
                chk(v[3:0] == ec, "R5 scan channel", v[3:0], ec);
                rd(3'd5, 1'b0, v);
                chk(v[6] == (ec == l), "R5 end of scan flag", v[6], ec == l);
                chk(v[5] == ((ec == l) && bm), "R11 eoa flag", v[5], (ec == l) && bm);
                ec = next_ch(ec, f, l);
            end
        end

        // R8 overrun
        wr(3'd3, 1'b0, 16'h0001);
        n0 = nstart;
        wr(3'd0, 1'b1, 16'h0000);
        wr(3'd0, 1'b1, 16'h0000);
        rd(3'd1, 1'b0, v); chk(v[4] == 1'b1, "R8 overrun in irq reg", v[4], 1);
        rd(3'd5, 1'b0, v); chk(v[2] == 1'b1, "R8 overrun set", v[2], 1);
        rd(3'd5, 1'b0, v); chk(v[2] == 1'b0, "R8 overrun cleared", v[2], 0);
        wait_idle();
        chk(nstart == n0 + 1, "R8 second trigger dropped", nstart - n0, 1);

        // R7 internal pacer: software ignored, pace_int starts
        wr(3'd2, 1'b0, 16'h0003);
        n0 = nstart;
        wr(3'd0, 1'b1, 16'h0000);
        repeat (3) @(negedge clk);
        chk(nstart == n0, "R7 sw ignored with int source", nstart - n0, 0);
        pulse_int(); wait_idle();
        chk(nstart == n0 + 1, "R7 internal pace", nstart - n0, 1);

        // R7 external pace with inverted polarity
        wr(3'd2, 1'b0, 16'h0004);
        wr(3'd2, 1'b0, 16'h0006);
        n0 = nstart;
        pulse_int();
        @(negedge clk); pace_ext = 1'b1;
        repeat (3) @(negedge clk);
        chk(nstart == n0, "R7 ext wrong edge", nstart - n0, 0);
        pace_ext = 1'b0;
        repeat (3) @(negedge clk);
        wait_idle();
        chk(nstart == n0 + 1, "R7 ext edge", nstart - n0, 1);

        // R12 gate
        wr(3'd2, 1'b0, 16'h000B);
        pace_gate = 1'b0;
        rd(3'd2, 1'b0, v); chk(v[6] == 1'b0, "R12 gate status low", v[6], 0);
        n0 = nstart;
        pulse_int();
        chk(nstart == n0, "R12 gate blocks", nstart - n0, 0);
        pace_gate = 1'b1;
        rd(3'd2, 1'b0, v); chk(v[6] == 1'b1, "R12 gate status high", v[6], 1);
        pulse_int(); wait_idle();
        chk(nstart == n0 + 1, "R12 gate passes", nstart - n0, 1);
        wr(3'd2, 1'b0, 16'h0000);

        // R9 fifo flags
        fifo_level = 0;
        rd(3'd5, 1'b0, v); chk(v[4:3] == 2'b00, "R9 empty", v[4:3], 0);
        fifo_level = 1;
        rd(3'd5, 1'b0, v); chk(v[4:3] == 2'b10, "R9 not empty", v[4:3], 2);
        fifo_level = LW'(DEPTH/2 - 1);
        rd(3'd5, 1'b0, v); chk(v[4:3] == 2'b10, "R9 below half", v[4:3], 2);
        fifo_level = LW'(DEPTH/2);
        rd(3'd5, 1'b0, v); chk(v[4:3] == 2'b11, "R9 half full", v[4:3], 3);
        fifo_level = 0;

        // R10 interrupt on end of conversion
        wr(3'd1, 1'b0, 16'h0040);
        wr(3'd1, 1'b0, 16'h0080);
        @(negedge clk); chk(irq == 1'b0, "R10 cleared pending", irq, 0);
        wr(3'd0, 1'b1, 16'h0000); wait_idle();
        chk(irq == 1'b1, "R10 irq on eoc", irq, 1);
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R10 sticky", irq, 1);
        wr(3'd1, 1'b0, 16'h00C0);
        @(negedge clk); chk(irq == 1'b0, "R10 clear by write", irq, 0);
        wr(3'd1, 1'b0, 16'h0000);
        wr(3'd0, 1'b1, 16'h0000); wait_idle();
        chk(irq == 1'b0, "R10 disabled irq low", irq, 0);
        rd(3'd1, 1'b0, v); chk(v[6] == 1'b1, "R10 pending while disabled", v[6], 1);

        // R11 select 3: half full vs end of acquisition
        fifo_level = LW'(DEPTH/2);
        wr(3'd1, 1'b0, 16'h00C3);
        @(negedge clk); chk(irq == 1'b1, "R11 half-full route", irq, 1);
        fifo_level = 0;
        wr(3'd1, 1'b0, 16'h00C7);
        @(negedge clk); chk(irq == 1'b0, "R11 eoa idle", irq, 0);
        wr(3'd3, 1'b0, 16'h0003);
        wr(3'd0, 1'b0, 16'h0077);
        wr(3'd0, 1'b1, 16'h0000); wait_idle();
        chk(irq == 1'b1, "R11 eoa route", irq, 1);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule